// File: doc/BRIEF.md
# MSI or Legacy Interrupt Router

This block takes one level-sensitive interrupt line from the local fabric and passes it to a PCIe endpoint core. Each interrupt goes out one of two ways: as a Message Signaled Interrupt request held until the core acknowledges it, or as a legacy INTx level that is asserted and deasserted. Only one source exists, so no vector or source number travels with a request. Building the message itself and decoding configuration space are left to the core.

The MSI enable flag lives in the message control half of the MSI capability, at bit 16 of the configuration dword at byte address 0x050. The core reports configuration writes to the router as a strobe, an address and a dword. The router stages the enable bit and applies it to a local mode copy a fixed number of cycles later. A busy output is high during that window. An interrupt edge that arrives while the copy is updating is not dropped and is not sent on the old path. It is held, then issued on whichever path the settled mode selects. If the interrupt input is tied low, no interrupt is ever generated.

Top module: `msi_intx_router`

## Requirements
- R1: While reset is applied and after it is released with inputs idle, `msi_req`, `intx_level` and `shadow_busy` are 0 and `msi_mode` is 0 (0 means the legacy INTx path, 1 means the MSI path).
- R2: Only a write strobe with `cfg_wr_addr` equal to 0x050 is taken as an update, and the staged enable value is bit 16 of `cfg_wr_data`. Writes to any other address leave `shadow_busy` at 0 and `msi_mode` unchanged.
- R3: `shadow_busy` goes high in the cycle after an accepted write and stays high for exactly SHADOW_DELAY cycles. `msi_mode` takes the staged value in the cycle `shadow_busy` falls. An accepted write during the window restarts it with the new value.
- R4: With `msi_mode` at 1 and `shadow_busy` at 0, a rising edge of `irq_src` raises `msi_req` in the next cycle. `msi_req` stays high until `msi_ack` is sampled high, and is low in the cycle after that.
- R5: A second MSI needs a new rising edge of `irq_src`: holding the source high after an acknowledge produces no request. A rising edge seen while a request is still waiting is remembered and issued in the cycle after the acknowledge.
- R6: With `msi_mode` at 0 and `shadow_busy` at 0, a rising edge of `irq_src` raises `intx_level` in the next cycle. It drops in the cycle after `irq_src` is sampled low.
- R7: A rising edge seen while `shadow_busy` is high issues nothing during the window. It is issued one cycle after `shadow_busy` falls, on the path the new `msi_mode` selects.
- R8: If `msi_mode` becomes 1 while `intx_level` is high, `intx_level` drops in the next cycle. No MSI is sent until `irq_src` falls and rises again.
- R9: With `irq_src` held low, neither `msi_req` nor `intx_level` is ever raised, whatever configuration writes arrive.
- R10: `msi_req` and `intx_level` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 1 | Interrupt level from the local fabric, synchronous to clk |
| cfg_wr_en | input | 1 | Configuration write strobe from the endpoint core |
| cfg_wr_addr | input | 12 | Byte address of the configuration write |
| cfg_wr_data | input | 32 | Configuration dword written |
| msi_req | output | 1 | MSI request, held until acknowledged |
| msi_ack | input | 1 | Acknowledge of the MSI request from the core |
| intx_level | output | 1 | Legacy interrupt level: high means asserted |
| shadow_busy | output | 1 | High while the mode copy is waiting to update |
| msi_mode | output | 1 | Settled mode copy: 1 selects MSI, 0 selects INTx |

## Verification
The bench builds the router with SHADOW_DELAY set to 5. This keeps the busy window short, so edges that land inside it, writes that restart it, and a mode change during a held INTx level can all be driven within a few dozen cycles. It also lets the exact window length be counted. The address and bit parameters keep their defaults, so the directed checks use the real capability address 0x050 and a neighbouring address that must be ignored.

// File: rtl/msi_intx_router_pkg.sv
package msi_intx_router_pkg;
  typedef enum logic [1:0] {
    DISP_IDLE = 2'd0,
    DISP_MSI  = 2'd1,
    DISP_INTX = 2'd2
  } disp_state_e;
endpackage

// File: rtl/msi_intx_router_rst_sync.sv
module msi_intx_router_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/msi_intx_router_cfg_shadow.sv
module msi_intx_router_cfg_shadow #(
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 32,
  parameter logic [11:0] CAP_ADDR     = 12'h050,
  parameter int          EN_BIT       = 16,
  parameter int          SHADOW_DELAY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              mode
);
  localparam int CNT_W = $clog2(SHADOW_DELAY + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              staged_q, staged_d;
  logic              mode_q, mode_d;
  logic              load;
  logic              cnt_en;
  logic [DATA_W-1:0] unused_wr_bits;

  assign unused_wr_bits = wr_data;
  assign load   = wr_en && (wr_addr == ADDR_W'(CAP_ADDR));
  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d    = cnt_q;
    staged_d = staged_q;
    mode_d   = mode_q;
    if (load) begin
      cnt_d    = CNT_W'(SHADOW_DELAY);
      staged_d = wr_data[EN_BIT];
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) mode_d = staged_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      staged_q <= 1'b0;
      mode_q   <= 1'b0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_d;
      staged_q <= staged_d;
      mode_q   <= mode_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign mode = mode_q;

  // R2 / R3: an accepted write opens the busy window next cycle
  assert_write_opens_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  // R3: the mode copy only moves at the end of a busy window
  assert_mode_stable_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mode));
  // R2: without any write strobe, an idle shadow stays idle
  assert_no_spurious_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> !busy);
endmodule

// File: rtl/msi_intx_router_dispatch.sv
module msi_intx_router_dispatch
  import msi_intx_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic ack,
  input  logic busy,
  input  logic mode,
  output logic msi_req,
  output logic intx_level
);
  disp_state_e state_q, state_d;
  logic        src_q;
  logic        pend_q, pend_d;
  logic        rise;

  assign rise = src && !src_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      DISP_IDLE: begin
        if ((rise || pend_q) && !busy) begin
          state_d = mode ? DISP_MSI : DISP_INTX;
          pend_d  = 1'b0;
        end else if (rise) begin
          pend_d = 1'b1;
        end
      end
      DISP_MSI: begin
        if (rise) pend_d = 1'b1;
        if (ack)  state_d = DISP_IDLE;
      end
      DISP_INTX: begin
        if (!src || mode) state_d = DISP_IDLE;
      end
      default: state_d = DISP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DISP_IDLE;
      pend_q  <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      src_q   <= src;
    end
  end

  assign msi_req    = (state_q == DISP_MSI);
  assign intx_level = (state_q == DISP_INTX);

  // R10
  assert_paths_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_req && intx_level));
  // R4: a request is held until acknowledged
  assert_msi_held_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req && !ack) |=> msi_req);
  // R6: the legacy level drops once the source is low
  assert_intx_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_level && !src) |=> !intx_level);
  // R7: nothing is issued while the mode copy is updating
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_req && !intx_level && busy) |=> (!msi_req && !intx_level));
  // R8: the legacy level is released once MSI mode is in force
  assert_intx_release_on_msi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_level && mode) |=> !intx_level);
  // R4 / R6: a new request only starts on the path the mode selects
  assert_no_msi_in_intx_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_req && !mode) |=> !msi_req);
  assert_no_intx_in_msi_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!intx_level && mode) |=> !intx_level);
endmodule

// File: rtl/msi_intx_router.sv
module msi_intx_router #(
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 32,
  parameter logic [11:0] CAP_ADDR     = 12'h050,
  parameter int          EN_BIT       = 16,
  parameter int          SHADOW_DELAY = 8,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_src,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic              msi_req,
  input  logic              msi_ack,
  output logic              intx_level,
  output logic              shadow_busy,
  output logic              msi_mode
);
  logic rst_n_int;
  logic busy_w;
  logic mode_w;

  msi_intx_router_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  msi_intx_router_cfg_shadow #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CAP_ADDR     (CAP_ADDR),
    .EN_BIT       (EN_BIT),
    .SHADOW_DELAY (SHADOW_DELAY)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .busy    (busy_w),
    .mode    (mode_w)
  );

  msi_intx_router_dispatch u_dispatch (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .src        (irq_src),
    .ack        (msi_ack),
    .busy       (busy_w),
    .mode       (mode_w),
    .msi_req    (msi_req),
    .intx_level (intx_level)
  );

  assign shadow_busy = busy_w;
  assign msi_mode    = mode_w;

  // R9: a source held low never raises either output
  assert_quiet_source_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!irq_src && !msi_req && !intx_level) |=> (!msi_req && !intx_level));
endmodule

// File: tb/msi_intx_router_tb_top.sv
module msi_intx_router_tb_top;
  localparam int DLY = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_src;
  logic        cfg_wr_en;
  logic [11:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic        msi_req;
  logic        msi_ack;
  logic        intx_level;
  logic        shadow_busy;
  logic        msi_mode;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  msi_intx_router #(.SHADOW_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .msi_req(msi_req), .msi_ack(msi_ack), .intx_level(intx_level),
    .shadow_busy(shadow_busy), .msi_mode(msi_mode)
  );

  // behavioural reference: path 0 idle, 1 msi waiting, 2 intx held
  int m_path, m_left;
  bit m_mode, m_staged, m_prev, m_held;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_path = 0; m_left = 0; m_mode = 0; m_staged = 0; m_prev = 0; m_held = 0;
    end else begin
      bit was_busy, old_mode, edge_seen;
      was_busy  = (m_left > 0);
      old_mode  = m_mode;
      edge_seen = irq_src && !m_prev;
      if (m_path == 0) begin
        if ((edge_seen || m_held) && !was_busy) begin
          m_path = old_mode ? 1 : 2; m_held = 0;
        end else if (edge_seen) m_held = 1;
      end else if (m_path == 1) begin
        if (edge_seen) m_held = 1;
        if (msi_ack) m_path = 0;
      end else begin
        if (!irq_src || old_mode) m_path = 0;
      end
      m_prev = irq_src;
      if (cfg_wr_en && cfg_wr_addr == 12'h050) begin
        m_left = DLY; m_staged = cfg_wr_data[16];
      end else if (m_left > 0) begin
        if (m_left == 1) m_mode = m_staged;
        m_left--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R4 msi_req vs model", {31'd0, msi_req}, {31'd0, m_path == 1});
    chk("R6 intx_level vs model", {31'd0, intx_level}, {31'd0, m_path == 2});
    chk("R3 shadow_busy vs model", {31'd0, shadow_busy}, {31'd0, m_left > 0});
    chk("R2 msi_mode vs model", {31'd0, msi_mode}, {31'd0, m_mode});
    chk("R10 exclusive outputs", {31'd0, msi_req & intx_level}, 32'd0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic wait_settled();
    while (shadow_busy) tick();
  endtask

  task automatic do_ack();
    msi_ack = 1'b1; tick(); msi_ack = 1'b0;
  endtask

  initial begin
    int width;
    rst_n = 1'b0; irq_src = 1'b0; cfg_wr_en = 1'b0;
    cfg_wr_addr = '0; cfg_wr_data = '0; msi_ack = 1'b0;
    repeat (4) tick();
    chk("R1 reset msi_req", {31'd0, msi_req}, 32'd0);
    chk("R1 reset intx", {31'd0, intx_level}, 32'd0);
    chk("R1 reset busy", {31'd0, shadow_busy}, 32'd0);
    chk("R1 reset mode", {31'd0, msi_mode}, 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after release mode", {31'd0, msi_mode}, 32'd0);

    // R6: legacy path
    irq_src = 1'b1; tick();
    chk("R6 intx raised", {31'd0, intx_level}, 32'd1);
    tick(); tick();
    irq_src = 1'b0; tick();
    chk("R6 intx dropped", {31'd0, intx_level}, 32'd0);

    // R2: wrong address ignored
    cfg_write(12'h054, 32'h0001_0000);
    chk("R2 other address no busy", {31'd0, shadow_busy}, 32'd0);
    repeat (DLY + 1) tick();
    chk("R2 other address mode kept", {31'd0, msi_mode}, 32'd0);

    // R7: edge inside window goes out as MSI after it closes
    cfg_write(12'h050, 32'h0001_0000);
    irq_src = 1'b1; tick();
    chk("R7 held during busy", {31'd0, msi_req | intx_level}, 32'd0);
    wait_settled();
    chk("R3 mode applied", {31'd0, msi_mode}, 32'd1);
    chk("R7 not yet issued", {31'd0, msi_req}, 32'd0);
    tick();
    chk("R7 issued on msi path", {31'd0, msi_req}, 32'd1);

    // R4 / R5
    tick(); tick();
    chk("R4 held until ack", {31'd0, msi_req}, 32'd1);
    do_ack();
    chk("R4 dropped after ack", {31'd0, msi_req}, 32'd0);
    repeat (5) tick();
    chk("R5 no repeat while high", {31'd0, msi_req}, 32'd0);
    irq_src = 1'b0; tick(); irq_src = 1'b1; tick();
    chk("R5 new edge requests", {31'd0, msi_req}, 32'd1);
    irq_src = 1'b0; tick(); irq_src = 1'b1; tick();
    do_ack();
    chk("R5 low after ack", {31'd0, msi_req}, 32'd0);
    tick();
    chk("R5 remembered edge issued", {31'd0, msi_req}, 32'd1);
    do_ack();
    irq_src = 1'b0; tick();

    // back to INTx, then R8
    cfg_write(12'h050, 32'h0000_0000);
    wait_settled();
    tick();
    irq_src = 1'b1; tick(); tick();
    chk("R6 intx in legacy mode", {31'd0, intx_level}, 32'd1);
    cfg_write(12'h050, 32'hFFFF_FFFF);
    wait_settled();
    chk("R8 intx kept until mode lands", {31'd0, intx_level}, 32'd1);
    tick();
    chk("R8 intx released", {31'd0, intx_level}, 32'd0);
    repeat (3) tick();
    chk("R8 no msi without new edge", {31'd0, msi_req}, 32'd0);
    irq_src = 1'b0; tick(); irq_src = 1'b1; tick();
    chk("R8 msi after new edge", {31'd0, msi_req}, 32'd1);
    do_ack();
    irq_src = 1'b0; tick();

    // R3: restart during window and window length
    cfg_write(12'h050, 32'h0000_0000);
    tick();
    cfg_write(12'h050, 32'h0001_0000);
    width = 0;
    while (shadow_busy) begin width++; tick(); end
    chk("R3 window length after restart", width, DLY);
    chk("R3 last write wins", {31'd0, msi_mode}, 32'd1);

    // R9: quiet source with config churn
    cfg_write(12'h050, 32'h0000_0000);
    repeat (DLY + 3) tick();
    cfg_write(12'h050, 32'h0001_0000);
    repeat (DLY + 3) tick();
    chk("R9 no output with source low", {31'd0, msi_req | intx_level}, 32'd0);

    repeat (4) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule